// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits beside a peripheral's register bus and watches every software access. It sorts each abnormal access into one of four typed classes, marks each class as a warning or an error, and keeps a record of writes that hit protected registers, together with the offset of the register that was targeted. Two fault inputs from elsewhere in the peripheral are also latched: an internal sequencer fault and a clock glitch. All of this state is packed into one read-only 32-bit status word. That word lives at bus offset 0xE8, and every field in it clears when it is read.

The register decoder supplies per-access qualifiers: the address is read-only, write-only, undefined, protected, or a configuration register. The surrounding logic supplies three level inputs. A protection-enable input arms write protection. A peripheral-enable input reports that the peripheral is running. A memory-live input is high when the refresh-count setting is non-zero, which means the memory device is already configured and initialized. When software reads offset 0xE8, the word appears combinationally on the read-data output in that same cycle, and the fields clear at the closing clock edge.

Top module: `acc_viol_monitor`

## Requirements
- R1: After reset, and before any event, the status word reads 0x00000000.
- R2: A software error sets bit 3 and loads a 2-bit type into bits 25:24. The types are: 0 for a read of a write-only register, 1 for a write to a read-only register, 2 for a read or write of an undefined address, and 3 for a write to a configuration register. When one access qualifies for several types, the type with the highest code wins.
- R3: Bit 31 is 1 exactly when a software error of type 3 is held. Types 0, 1 and 2 leave bit 31 at 0.
- R4: Type 3 is raised only while the memory-live input is high, and type 1 is raised only while the peripheral-enable input is high.
- R5: A write to a protected address while protection is enabled sets bit 0 and captures the access address, zero-extended to 16 bits, in bits 23:8.
- R6: A high sequencer-fault input sets bit 2, and a high clock-glitch input sets bit 1. Both stay set after the input falls.
- R7: A read at offset 0xE8 returns the status word on the read-data output in that cycle and clears every field at the following edge. Any other read returns zero, and any other access leaves the word unchanged.
- R8: An event that coincides with a status read is missing from that read's data and present in the next read.
- R9: While bit 3 is held, later software errors do not change bits 25:24. While bit 0 is held, later protected writes do not change bits 23:8.
- R10: Bits 30:26 and bits 7:4 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the current access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 32 | Status word during a read of offset 0xE8, zero otherwise |
| dec_ro | input | 1 | Address decodes to a read-only register |
| dec_wo | input | 1 | Address decodes to a write-only register |
| dec_undef | input | 1 | Address decodes to no register |
| dec_cfg | input | 1 | Address decodes to a configuration register |
| dec_prot | input | 1 | Address decodes to a write-protected register |
| prot_en | input | 1 | Write protection armed |
| periph_en | input | 1 | Peripheral running |
| mem_live | input | 1 | Refresh count non-zero: memory configured and initialized |
| seq_fault | input | 1 | Internal sequencer fault indication |
| clk_glitch | input | 1 | Clock glitch indication |

## Verification
The assertions check on every cycle that held flags survive until a status read, that the captured type and offset do not change while their flags are set, that a qualifying configuration write loads type 3 with the error class, that a status read clears the sequencer flag, and that non-status reads return zero. The bench's scenarios are the only place that shows the full type priority across every combination of qualifiers and enables, an event coinciding with a read, and first-event retention across several events. The bench sweeps all 4096 combinations of the twelve access and fault inputs and follows each one with two status reads.

// File: rtl/avm_pkg.sv
// Package: shared types and field positions for the access violation monitor.
// Assumes a 32-bit status word and offsets of at most 16 bits.
package avm_pkg;
    localparam int STAT_W = 32;
    localparam int OFFS_W = 16;

    typedef enum logic [1:0] {
        SWE_RD_WO    = 2'd0,
        SWE_WR_RO    = 2'd1,
        SWE_UNDEF    = 2'd2,
        SWE_LATE_CFG = 2'd3
    } swe_type_e;

    // Positions of the single-bit flags in the status word.
    localparam int B_WPV = 0;
    localparam int B_CGD = 1;
    localparam int B_SEQ = 2;
    localparam int B_SWE = 3;
    localparam int B_CLS = 31;
endpackage

// File: rtl/avm_classify.sv
// Module: avm_classify
// Combinationally classifies one bus access into a software error type.
// Assumes the decode qualifiers are valid in the same cycle as the strobes.
// When several types apply, the higher code wins.
module avm_classify
    import avm_pkg::*;
(
    input  logic      acc_rd,
    input  logic      acc_wr,
    input  logic      is_ro,
    input  logic      is_wo,
    input  logic      is_undef,
    input  logic      is_cfg,
    input  logic      periph_en,
    input  logic      mem_live,
    output logic      swe_evt,
    output swe_type_e swe_type
);
    // Priority pick of the error type for the current access.
    always_comb begin
        swe_evt  = 1'b1;
        swe_type = SWE_RD_WO;
        if (acc_wr && is_cfg && mem_live)
            swe_type = SWE_LATE_CFG;
        else if ((acc_rd || acc_wr) && is_undef)
            swe_type = SWE_UNDEF;
        else if (acc_wr && is_ro && periph_en)
            swe_type = SWE_WR_RO;
        else if (acc_rd && is_wo)
            swe_type = SWE_RD_WO;
        else
            swe_evt = 1'b0;
    end
endmodule

// File: rtl/avm_flag.sv
// Module: avm_flag
// Sticky single-bit flag. A clear request is applied first, and an event in
// the same cycle then sets the flag, so the event is not lost.
module avm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt,
    output logic flag
);
    // Hold, clear on read, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !clr) || evt;
    end
endmodule

// File: rtl/avm_capture.sv
// Module: avm_capture
// Field that keeps the data of the first event since the last clear.
// Assumes `held` is the sticky flag that belongs to this field.
module avm_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         held,
    input  logic         evt,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Load on the first event; otherwise zero on clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                     q <= '0;
        else if (evt && (!held || clr)) q <= din;
        else if (clr)                   q <= '0;
    end
endmodule

// File: rtl/acc_viol_monitor.sv
// Module: acc_viol_monitor (top)
// Watches register bus accesses and records software errors, protected-write
// violations, a sequencer fault and a clock glitch in one clear-on-read status
// word at STAT_ADDR. Assumes ADDR_W <= 16 and single-cycle access strobes.
module acc_viol_monitor
    import avm_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'h00E8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [31:0]       bus_rdata,
    input  logic              dec_ro,
    input  logic              dec_wo,
    input  logic              dec_undef,
    input  logic              dec_cfg,
    input  logic              dec_prot,
    input  logic              prot_en,
    input  logic              periph_en,
    input  logic              mem_live,
    input  logic              seq_fault,
    input  logic              clk_glitch
);
    localparam int NFLAG = 4;

    logic              stat_rd;
    logic              swe_evt;
    swe_type_e         swe_type;
    logic              wpv_evt;
    logic [NFLAG-1:0]  evt_vec;
    logic [NFLAG-1:0]  flags;
    logic [1:0]        type_q;
    logic [OFFS_W-1:0] offs_q;
    logic [STAT_W-1:0] status_word;

    // Status read strobe: it clears every field at the closing edge.
    always_comb stat_rd = bus_rd && (OFFS_W'(bus_addr) == STAT_ADDR);

    // Protected write while protection is armed.
    always_comb wpv_evt = bus_wr && dec_prot && prot_en;

    avm_classify i_classify (
        .acc_rd    (bus_rd),
        .acc_wr    (bus_wr),
        .is_ro     (dec_ro),
        .is_wo     (dec_wo),
        .is_undef  (dec_undef),
        .is_cfg    (dec_cfg),
        .periph_en (periph_en),
        .mem_live  (mem_live),
        .swe_evt   (swe_evt),
        .swe_type  (swe_type)
    );

    // Gather the event sources in flag-bit order.
    always_comb begin
        evt_vec        = '0;
        evt_vec[B_WPV] = wpv_evt;
        evt_vec[B_CGD] = clk_glitch;
        evt_vec[B_SEQ] = seq_fault;
        evt_vec[B_SWE] = swe_evt;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        avm_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (stat_rd),
            .evt   (evt_vec[g]),
            .flag  (flags[g])
        );
    end

    avm_capture #(.W(2)) i_type_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_rd),
        .held  (flags[B_SWE]),
        .evt   (swe_evt),
        .din   (swe_type),
        .q     (type_q)
    );

    avm_capture #(.W(OFFS_W)) i_offs_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_rd),
        .held  (flags[B_WPV]),
        .evt   (wpv_evt),
        .din   (OFFS_W'(bus_addr)),
        .q     (offs_q)
    );

    // Pack the status word; the class follows from the held type.
    always_comb begin
        status_word        = '0;
        status_word[3:0]   = flags;
        status_word[23:8]  = offs_q;
        status_word[25:24] = type_q;
        status_word[B_CLS] = flags[B_SWE] && (type_q == SWE_LATE_CFG);
    end

    // Read data: the status word on a status read, zero otherwise.
    always_comb bus_rdata = stat_rd ? status_word : '0;
endmodule

// File: rtl/avm_checker.sv
// Module: avm_checker
// Concurrent checks on the monitor, bound into every acc_viol_monitor instance.
module avm_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              dec_cfg,
    input logic              dec_prot,
    input logic              prot_en,
    input logic              mem_live,
    input logic              seq_fault,
    input logic              stat_rd,
    input logic [31:0]       status_word,
    input logic [31:0]       bus_rdata
);
    // R3, R4: a configuration write while the memory is live loads type 3 and the error class.
    a_r3_late_cfg_class: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_cfg && mem_live && !status_word[3])
        |=> (status_word[25:24] == 2'd3 && status_word[31] && status_word[3]));

    // R5: a protected write captures its address.
    a_r5_wp_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_prot && prot_en && !status_word[0])
        |=> (status_word[0] && status_word[23:8] == 16'($past(bus_addr))));

    // R9: the software error flag stays set and its type stays stable until a read.
    a_r9_first_type: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[3] && !stat_rd) |=> (status_word[3] && $stable(status_word[25:24])));

    // R9: the captured offset stays stable while the protection flag is held.
    a_r9_first_offs: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] && !stat_rd) |=> $stable(status_word[23:8]));

    // R7: a status read with no new sequencer fault clears bit 2.
    a_r7_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !seq_fault) |=> !status_word[2]);

    // R7: reads of other offsets return zero.
    a_r7_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |-> (bus_rdata == 32'd0));
endmodule

bind acc_viol_monitor avm_checker #(.ADDR_W(ADDR_W)) i_avm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .dec_cfg     (dec_cfg),
    .dec_prot    (dec_prot),
    .prot_en     (prot_en),
    .mem_live    (mem_live),
    .seq_fault   (seq_fault),
    .stat_rd     (stat_rd),
    .status_word (status_word),
    .bus_rdata   (bus_rdata)
);

// File: tb/test_acc_viol_monitor.sv
// Bench: sweeps all 4096 combinations of access and fault inputs, then runs directed cases.
module test_acc_viol_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [31:0] bus_rdata;
    logic        dec_ro = 0, dec_wo = 0, dec_undef = 0, dec_cfg = 0, dec_prot = 0;
    logic        prot_en = 0, periph_en = 0, mem_live = 0, seq_fault = 0, clk_glitch = 0;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    always #2 clk = ~clk;  // 250 MHz

    acc_viol_monitor i_acc_viol_monitor (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; dec_ro = 0; dec_wo = 0; dec_undef = 0; dec_cfg = 0;
        dec_prot = 0; seq_fault = 0; clk_glitch = 0; bus_addr = 16'h0000;
    endtask

    // Apply one combination for a cycle: bits rd,wr,ro,wo,undef,cfg,en,live,prot,pen,seq,glt.
    task automatic apply(input logic [11:0] c, input logic [15:0] a);
        @(negedge clk);
        bus_rd = c[0]; bus_wr = c[1]; dec_ro = c[2]; dec_wo = c[3]; dec_undef = c[4];
        dec_cfg = c[5]; periph_en = c[6]; mem_live = c[7]; dec_prot = c[8];
        prot_en = c[9]; seq_fault = c[10]; clk_glitch = c[11]; bus_addr = a;
    endtask

    // Read the status word; return the data seen in the read cycle.
    task automatic read_stat(output logic [31:0] d);
        @(negedge clk);
        idle();
        bus_rd = 1; bus_addr = 16'h00E8;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] model(input logic [11:0] c, input logic [15:0] a);
        logic [31:0] w = '0;
        logic rd = c[0], wr = c[1];
        logic sw = 1'b1;
        logic [1:0] t = 2'd0;
        if (wr && c[5] && c[7])          t = 2'd3;
        else if ((rd || wr) && c[4])     t = 2'd2;
        else if (wr && c[2] && c[6])     t = 2'd1;
        else if (rd && c[3])             t = 2'd0;
        else                             sw = 1'b0;
        w[3] = sw;
        w[25:24] = sw ? t : 2'd0;
        w[31] = sw && (t == 2'd3);
        if (wr && c[8] && c[9]) begin w[0] = 1'b1; w[23:8] = a; end
        w[2] = c[10];
        w[1] = c[11];
        return w;
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        read_stat(d);
        check("R1 reset word", d, 32'h0);

        // Sweep: R2 R3 R4 R5 R6 R10 on the first read, R7 on the second.
        for (int i = 0; i < 4096; i++) begin
            logic [15:0] a = 16'h1000 + 16'(i);
            apply(12'(i), a);
            read_stat(d);
            check("R2/R3/R4/R5/R6/R10 sweep", d, model(12'(i), a));
            read_stat(d);
            check("R7 cleared after read", d, 32'h0);
        end

        // R7: a read of another offset returns zero and leaves the word untouched.
        apply(12'h401, 16'h0100);      // sequencer fault together with a plain read
        #1 check("R7 other read zero", bus_rdata, 32'h0);
        read_stat(d);
        check("R7 word kept", d, 32'h0000_0004);

        // R8: an event coinciding with a status read survives to the next read.
        apply(12'h400, 16'h0010);
        @(negedge clk);
        idle(); bus_rd = 1; bus_addr = 16'h00E8; clk_glitch = 1;
        #1 check("R8 coincide old value", bus_rdata, 32'h0000_0004);
        read_stat(d);
        check("R8 event kept", d, 32'h0000_0002);

        // R9: the first software error type and the first protected offset are kept.
        apply(12'h009, 16'h0020);      // read of write-only: type 0
        apply(12'h0C2 | 12'h020, 16'h0024); // config write while live: type 3
        apply(12'h302, 16'h0030);      // protected write at 0x30
        apply(12'h302, 16'h0044);      // protected write at 0x44
        read_stat(d);
        check("R9 first type and offset", d, 32'h0000_3009);
        read_stat(d);
        check("R9 cleared", d, 32'h0);

        // R4: no type 3 when the memory is not live, no type 1 when disabled.
        apply(12'h022, 16'h0050);
        apply(12'h006, 16'h0054);
        read_stat(d);
        check("R4 gated types", d, 32'h0);

        // R2/R3: configuration write after init, alone.
        apply(12'h0A2, 16'h0058);
        read_stat(d);
        check("R3 error class", d, 32'h8300_0008);
        done = 1;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog got=hung exp=done");
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule